// File: doc/BRIEF.md
# USB device interrupt status and routing

This block keeps the eight device-level interrupt flags of a USB device controller. Single-cycle event strobes from the controller core set the flags: frame tick, bus reset, suspend change, connect change, command register empty, command data full, receive packet done and transmit byte written. Each flag stays set until software clears it. A per-endpoint interrupt vector is split into a fast flag and a slow flag by a per-endpoint priority mask. The block compares a running count of transmit bytes against the programmed packet length to decide when the transmit-end flag fires.

Software works through one write port with four targets: a clear target (write 1s to clear), a set target (write 1s to set), a per-flag enable mask and a global enable. The flag vector can be read at all times. A single interrupt line is the OR of the enabled flags, gated by the global enable.

Top module: `usb_dev_irq_router`

## Requirements
- R1: After reset the flag vector is 0x10 (only command-empty set), the per-flag enable mask is 0, the global enable is 1 and `irq_o` is 0.
- R2: The flag positions are: bit 0 frame, bit 4 command empty, bit 5 command data full, bit 6 receive packet end. A strobe on `frame_tick_i`, `cmd_empty_i`, `cmd_full_i` or `rx_done_i` sets its bit on the next clock edge.
- R3: Bit 1 (fast endpoint) is set when any endpoint has both its `ep_int_i` bit and its `ep_pri_i` bit at 1. Bit 2 (slow endpoint) is set when any endpoint has its `ep_int_i` bit at 1 and its `ep_pri_i` bit at 0.
- R4: Bit 3 (device status) is set by a strobe on any one of `bus_reset_i`, `suspend_chg_i` or `connect_chg_i`.
- R5: Bit 7 (transmit end) is set by the `tx_byte_i` strobe that makes the number of bytes written since the last completion (or since reset) equal `tx_len_i`. The count then restarts from zero. When `tx_len_i` is 0 the bit is never set.
- R6: A write with `reg_sel`=0 clears every flag whose `reg_wdata` bit is 1 and leaves the flags whose bit is 0 unchanged. A flag never falls to 0 except through such a write or a reset.
- R7: A write with `reg_sel`=1 sets every flag whose `reg_wdata` bit is 1.
- R8: When a hardware event and a clear write hit the same flag in the same cycle, the flag ends up set.
- R9: A write with `reg_sel`=2 loads the per-flag enable mask from `reg_wdata`. `irq_o` equals the global enable ANDed with the OR of (flags AND enable mask).
- R10: A write with `reg_sel`=3 loads the global enable from `reg_wdata[0]`. While it is 0, `irq_o` stays 0 whatever the flags and mask hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick_i | input | 1 | Frame strobe, once per 1 ms |
| bus_reset_i | input | 1 | Bus reset event strobe |
| suspend_chg_i | input | 1 | Suspend change event strobe |
| connect_chg_i | input | 1 | Connect change event strobe |
| cmd_empty_i | input | 1 | Command register became empty |
| cmd_full_i | input | 1 | Command data register became full |
| rx_done_i | input | 1 | Receive packet fully moved to the CPU |
| tx_byte_i | input | 1 | One byte written into the transmit buffer |
| tx_len_i | input | LEN_W | Programmed transmit packet length |
| ep_int_i | input | N_EP | Per-endpoint interrupt requests |
| ep_pri_i | input | N_EP | Per-endpoint priority mask, 1 = fast |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 clear, 1 set, 2 enable mask, 3 global enable |
| reg_wdata | input | 8 | Write data |
| status_o | output | 8 | Current flag vector |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest case to reach is the transmit-end flag. It depends on a hidden byte count that carries over from one packet to the next, so the bench resets the block before each programmed length and runs a long train of byte strobes. After each strobe it checks the flag against the strobe index modulo the length, and clears the flag between strobes so that every completion is seen on its own. The race between a hardware set and a software clear is reached by timing a clear write into the same cycle as an event strobe. The interrupt gating is swept over every flag pattern under several enable masks and both global enable values.

// File: rtl/usb_dev_irq_router.sv
module usb_dev_irq_router #(
  parameter int N_EP  = 16,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick_i,
  input  logic             bus_reset_i,
  input  logic             suspend_chg_i,
  input  logic             connect_chg_i,
  input  logic             cmd_empty_i,
  input  logic             cmd_full_i,
  input  logic             rx_done_i,
  input  logic             tx_byte_i,
  input  logic [LEN_W-1:0] tx_len_i,
  input  logic [N_EP-1:0]  ep_int_i,
  input  logic [N_EP-1:0]  ep_pri_i,
  input  logic             reg_we,
  input  logic [1:0]       reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       status_o,
  output logic             irq_o
);
  localparam logic [7:0] ST_RST = 8'h10;
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [7:0]       st_q, en_q;
  logic             glb_q;
  logic [LEN_W-1:0] tx_cnt_q;

  wire       wr_clr = reg_we && (reg_sel == 2'd0);
  wire       wr_set = reg_we && (reg_sel == 2'd1);
  wire       wr_en  = reg_we && (reg_sel == 2'd2);
  wire       wr_glb = reg_we && (reg_sel == 2'd3);
  wire [7:0] clr_mask = wr_clr ? reg_wdata : 8'h00;
  wire [7:0] set_mask = wr_set ? reg_wdata : 8'h00;

  wire tx_hit = tx_byte_i && (tx_len_i != '0) && (tx_cnt_q == tx_len_i - ONE);

  wire [7:0] hw_set = {tx_hit, rx_done_i, cmd_full_i, cmd_empty_i,
                       bus_reset_i | suspend_chg_i | connect_chg_i,
                       |(ep_int_i & ~ep_pri_i), |(ep_int_i & ep_pri_i),
                       frame_tick_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_RST;
      en_q     <= 8'h00;
      glb_q    <= 1'b1;
      tx_cnt_q <= '0;
    end else begin
      st_q <= (st_q & ~clr_mask) | hw_set | set_mask;
      if (wr_en)  en_q  <= reg_wdata;
      if (wr_glb) glb_q <= reg_wdata[0];
      if (tx_hit)         tx_cnt_q <= '0;
      else if (tx_byte_i) tx_cnt_q <= tx_cnt_q + ONE;
    end
  end

  assign status_o = st_q;
  assign irq_o    = glb_q & |(st_q & en_q);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(st_q) & ~$past(clr_mask)) & ~st_q) == 8'h00));

  // R8
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[0] && frame_tick_i) |=> st_q[0]);

  // R3
  fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ep_int_i & ep_pri_i) != '0) |=> st_q[1]);

  // R3
  slow_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ep_int_i & ~ep_pri_i) != '0) |=> st_q[2]);

  // R4
  dev_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i || suspend_chg_i || connect_chg_i) |=> st_q[3]);

  // R5
  tx_zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_len_i == '0 && !st_q[7] && !wr_set) |=> !st_q[7]);

  // R10
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_glb && !reg_wdata[0]) |=> !irq_o);
endmodule

// File: tb/sim_usb_dev_irq_router.sv
`timescale 1ns/1ps
module sim_usb_dev_irq_router;
  localparam int N_EP = 4;
  localparam int LEN_W = 3;

  logic clk = 0, rst_n = 0;
  logic frame_tick_i = 0, bus_reset_i = 0, suspend_chg_i = 0, connect_chg_i = 0;
  logic cmd_empty_i = 0, cmd_full_i = 0, rx_done_i = 0, tx_byte_i = 0;
  logic [LEN_W-1:0] tx_len_i = '0;
  logic [N_EP-1:0] ep_int_i = '0, ep_pri_i = '0;
  logic reg_we = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] status_o;
  logic irq_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  usb_dev_irq_router #(.N_EP(N_EP), .LEN_W(LEN_W)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic strobe(input int idx);
    @(negedge clk);
    case (idx)
      0: frame_tick_i = 1;  1: bus_reset_i = 1;  2: suspend_chg_i = 1;
      3: connect_chg_i = 1; 4: cmd_empty_i = 1;  5: cmd_full_i = 1;
      6: rx_done_i = 1;     default: tx_byte_i = 1;
    endcase
    @(negedge clk);
    {frame_tick_i, bus_reset_i, suspend_chg_i, connect_chg_i} = 0;
    {cmd_empty_i, cmd_full_i, rx_done_i, tx_byte_i} = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] exp_st;
    do_reset();
    chk("R1 status", status_o, 8'h10);
    chk("R1 irq", irq_o, 0);
    wr(2, 8'h10);
    chk("R1 global enable 1 at reset", irq_o, 1);
    wr(2, 8'h00);

    // R2 / R4: each event alone gives an exact flag vector
    for (int e = 0; e < 7; e++) begin
      wr(0, 8'hFF);
      strobe(e);
      exp_st = (e == 0) ? 8'h01 : (e <= 3) ? 8'h08 : (8'h01 << e);
      chk((e >= 1 && e <= 3) ? "R4 device status event" : "R2 event bit", status_o, exp_st);
    end

    // R3: sweep every request and priority pattern
    for (int i = 0; i < 16; i++)
      for (int p = 0; p < 16; p++) begin
        wr(0, 8'hFF);
        @(negedge clk); ep_int_i = i[3:0]; ep_pri_i = p[3:0];
        @(negedge clk); ep_int_i = '0;
        chk("R3 fast/slow routing", status_o[2:1],
            {2'b00, ((i & ~p & 15) != 0), ((i & p) != 0)});
      end

    // R6 / R7: clear and set masks
    wr(0, 8'hFF);
    wr(1, 8'hA5);
    chk("R7 set mask", status_o, 8'hA5);
    wr(0, 8'h0F);
    chk("R6 clear mask", status_o, 8'hA0);
    wr(0, 8'h00);
    chk("R6 zero clear no effect", status_o, 8'hA0);

    // R8: frame strobe and clear of bit 0 and 6 in same cycle
    wr(1, 8'h40);
    @(negedge clk); reg_we = 1; reg_sel = 0; reg_wdata = 8'h41; frame_tick_i = 1;
    @(negedge clk); reg_we = 0; frame_tick_i = 0;
    chk("R8 set beats clear", status_o, 8'hA1);

    // R9 / R10: sweep flags under several enable masks and both global values
    for (int g = 0; g < 2; g++) begin
      wr(3, g[7:0]);
      for (int m = 0; m < 10; m++) begin
        logic [7:0] en;
        en = (m < 8) ? (8'h01 << m) : (m == 8 ? 8'h00 : 8'hFF);
        wr(2, en);
        for (int s = 0; s < 256; s++) begin
          wr(0, 8'hFF);
          wr(1, s[7:0]);
          chk(g ? "R9 irq combine" : "R10 global gate", irq_o,
              g & ((s & en) != 0));
        end
      end
    end
    wr(3, 8'h01);
    wr(2, 8'h00);

    // R5: byte count against programmed length, each length from reset
    for (int len = 0; len < 8; len++) begin
      do_reset();
      tx_len_i = len[LEN_W-1:0];
      wr(0, 8'hFF);
      for (int k = 1; k <= 17; k++) begin
        strobe(7);
        chk("R5 tx end", status_o[7], (len != 0) && (k % (len == 0 ? 1 : len) == 0));
        wr(0, 8'h80);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule